// File: doc/BRIEF.md
# Condition test and loop-decrement unit

This unit decides whether one of sixteen branch conditions holds for a given set of condition flags, and applies that verdict to one of several consumers: a set-on-condition operation that produces an all-ones or all-zeros byte, a conditional branch that reports whether it is taken, and a counted-loop primitive that decrements a loop counter. The loop primitive leaves the loop early if the condition holds. Otherwise it keeps looping until the counter wraps past zero. Program counter arithmetic and instruction decoding live elsewhere. The caller supplies the selected condition, the flags, the counter and the operation. The unit returns the verdict, the byte, the taken bit and the new counter value.

Requests enter on a valid/ready channel, and results leave on a second valid/ready channel one cycle after acceptance. A single result register sits between them. A request is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle, so back-to-back requests flow at one per cycle while `out_ready` stays high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted. The flags are only read, so none of the operations alters them.

Top module: `cond_branch_unit`

## Requirements
- R1: The condition select `cc_sel` uses this encoding: 0 always, 1 never, 2 higher (C=0 and Z=0), 3 lower-or-same (C=1 or Z=1), 4 carry clear, 5 carry set, 6 not equal (Z=0), 7 equal (Z=1), 8 no overflow (V=0), 9 overflow (V=1), 10 plus (N=0), 11 minus (N=1), 12 greater-or-equal (N==V), 13 less (N!=V), 14 greater (N==V and Z=0), 15 less-or-equal (the inverse of 14). `ccr` is laid out as X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0. `cond_true` reports the result, and the X bit has no effect on any condition.
- R2: For every operation, `set_byte` is 8'hFF when the condition is true and 8'h00 when it is false.
- R3: With `op`=1 (branch), `taken` equals the condition result and `cnt_out` equals `cnt_in`.
- R4: With `op`=2 (loop) and the condition true, the unit falls through: `taken` is 0 and `cnt_out` equals `cnt_in`.
- R5: With `op`=2 and the condition false, the low 16 bits of the counter are decremented modulo 2^16. `taken` is 1 unless the decremented low half equals 16'hFFFF.
- R6: Bits 31:16 of `cnt_out` always equal bits 31:16 of `cnt_in`.
- R7: With `op`=0 (set) or `op`=3 (test only), `taken` is 0 and `cnt_out` equals `cnt_in`.
- R8: A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. The result of an accepted request is presented with `out_valid` high on the next cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and every result output hold their values.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| op | input | 2 | 0 set, 1 branch, 2 loop, 3 test only |
| cc_sel | input | 4 | Condition select |
| ccr | input | 5 | Condition flags X,N,Z,V,C |
| cnt_in | input | 32 | Loop counter |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| cond_true | output | 1 | Selected condition holds |
| set_byte | output | 8 | All ones if true, zeros if false |
| taken | output | 1 | Branch or loop-back taken |
| cnt_out | output | 32 | Updated counter |

## Verification
The hardest case to reach is the loop wrap. Here the condition is false and the low counter half is exactly zero, so it wraps to 16'hFFFF and the loop exits while the upper half must stay intact. Random counters almost never hit that point. The stimulus therefore drives low halves of 0, 1, 2 and 16'hFFFF with random upper halves, under the always-false and always-true selects, and also sweeps all flag patterns. Back-pressure is produced by randomly deasserting `out_ready` while requests keep arriving, which exercises the hold path and the stalled `in_ready`.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef enum logic [1:0] {
    OP_SET    = 2'd0,
    OP_BRANCH = 2'd1,
    OP_LOOP   = 2'd2,
    OP_TEST   = 2'd3
  } cbu_op_e;

  localparam int FLAG_W  = 5;
  localparam int SEL_W   = 4;
  localparam int NUM_CC  = 1 << SEL_W;
  localparam int NUM_PAIR = NUM_CC / 2;

  localparam int FL_X = 4;
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cbu_flags_t;

  function automatic cbu_flags_t unpack_flags(input logic [FLAG_W-1:0] f);
    cbu_flags_t r;
    r.n = f[FL_N];
    r.z = f[FL_Z];
    r.v = f[FL_V];
    r.c = f[FL_C];
    return r;
  endfunction

endpackage

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);
  cbu_flags_t fl;
  logic [NUM_PAIR-1:0] base;
  logic [NUM_CC-1:0]   truth;

  assign fl = unpack_flags(flags);

  // Even codes carry the positive sense, odd codes its inverse.
  always_comb begin
    base[0] = 1'b1;
    base[1] = ~fl.c & ~fl.z;
    base[2] = ~fl.c;
    base[3] = ~fl.z;
    base[4] = ~fl.v;
    base[5] = ~fl.n;
    base[6] = ~(fl.n ^ fl.v);
    base[7] = ~(fl.n ^ fl.v) & ~fl.z;
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assign truth[2*p]   = base[p];
    assign truth[2*p+1] = ~base[p];
  end

  assign hit = truth[sel];
endmodule

// File: rtl/cbu_loop_step.sv
module cbu_loop_step #(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             dec_en,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrapped
);
  logic [LOOP_W-1:0] low_in;
  logic [LOOP_W-1:0] low_dec;

  assign low_in  = cnt_in[LOOP_W-1:0];
  assign low_dec = low_in - LOOP_W'(1);
  // Decrementing from zero lands on all ones, the loop exit point.
  assign wrapped = dec_en & (low_in == '0);

  if (LOOP_W < CNT_W) begin : g_split
    assign cnt_next = dec_en ? {cnt_in[CNT_W-1:LOOP_W], low_dec} : cnt_in;
  end else begin : g_full
    assign cnt_next = dec_en ? low_dec : cnt_in;
  end
endmodule

// File: rtl/cbu_out_reg.sv
module cbu_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  output logic         q_valid,
  input  logic         q_ready,
  output logic [W-1:0] q_data
);
  assign load_ready = ~q_valid | q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (load_ready) begin
      q_valid <= load_valid;
      if (load_valid) q_data <= load_data;
    end
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        op,
  input  logic [SEL_W-1:0]  cc_sel,
  input  logic [FLAG_W-1:0] ccr,
  input  logic [CNT_W-1:0]  cnt_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              cond_true,
  output logic [BYTE_W-1:0] set_byte,
  output logic              taken,
  output logic [CNT_W-1:0]  cnt_out
);
  localparam int RES_W = 1 + BYTE_W + 1 + CNT_W;

  cbu_op_e          op_e;
  logic             hit;
  logic             dec_en;
  logic             wrapped;
  logic [CNT_W-1:0] cnt_next;
  logic             take_nx;
  logic [RES_W-1:0] res_d;
  logic [RES_W-1:0] res_q;

  assign op_e = cbu_op_e'(op);

  cbu_cond_eval u_eval (
    .sel   (cc_sel),
    .flags (ccr),
    .hit   (hit)
  );

  assign dec_en = (op_e == OP_LOOP) & ~hit;

  cbu_loop_step #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_step (
    .cnt_in   (cnt_in),
    .dec_en   (dec_en),
    .cnt_next (cnt_next),
    .wrapped  (wrapped)
  );

  always_comb begin
    unique case (op_e)
      OP_BRANCH: take_nx = hit;
      OP_LOOP:   take_nx = dec_en & ~wrapped;
      default:   take_nx = 1'b0;
    endcase
  end

  assign res_d = {hit, {BYTE_W{hit}}, take_nx, cnt_next};

  cbu_out_reg #(.W(RES_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (in_valid),
    .load_ready (in_ready),
    .load_data  (res_d),
    .q_valid    (out_valid),
    .q_ready    (out_ready),
    .q_data     (res_q)
  );

  assign {cond_true, set_byte, taken, cnt_out} = res_q;
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        op,
  input logic [CNT_W-1:0]  cnt_in,
  input logic              out_valid,
  input logic              out_ready,
  input logic              cond_true,
  input logic [BYTE_W-1:0] set_byte,
  input logic              taken,
  input logic [CNT_W-1:0]  cnt_out
);
  logic [1:0]       cap_op;
  logic [CNT_W-1:0] cap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_op  <= 2'd0;
      cap_cnt <= '0;
    end else if (in_valid && in_ready) begin
      cap_op  <= op;
      cap_cnt <= cnt_in;
    end
  end

  a_r2_set_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> set_byte == (cond_true ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}}));

  a_r3_branch: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_op == 2'd1 |-> taken == cond_true && cnt_out == cap_cnt);

  a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_op == 2'd2 && cond_true |-> !taken && cnt_out == cap_cnt);

  a_r5_wrap_exit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_op == 2'd2 && !cond_true && cap_cnt[LOOP_W-1:0] == '0
    |-> !taken && cnt_out[LOOP_W-1:0] == {LOOP_W{1'b1}});

  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cnt_out[CNT_W-1:LOOP_W] == cap_cnt[CNT_W-1:LOOP_W]);

  a_r7_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (cap_op == 2'd0 || cap_op == 2'd3) |-> !taken && cnt_out == cap_cnt);

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cond_true) && $stable(set_byte)
                                 && $stable(taken) && $stable(cnt_out));
endmodule

bind cond_branch_unit cond_branch_unit_chk #(
  .CNT_W(CNT_W), .LOOP_W(LOOP_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .cnt_in    (cnt_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .cond_true (cond_true),
  .set_byte  (set_byte),
  .taken     (taken),
  .cnt_out   (cnt_out)
);

// File: tb/cond_branch_unit_test.sv
module cond_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'd0;
  logic [3:0]  cc_sel = 4'd0;
  logic [4:0]  ccr = 5'd0;
  logic [31:0] cnt_in = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        cond_true;
  logic [7:0]  set_byte;
  logic        taken;
  logic [31:0] cnt_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    int          op;
    bit          c;
    bit          t;
    logic [31:0] cnt;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  cond_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .cc_sel(cc_sel), .ccr(ccr), .cnt_in(cnt_in),
    .out_valid(out_valid), .out_ready(out_ready), .cond_true(cond_true),
    .set_byte(set_byte), .taken(taken), .cnt_out(cnt_out)
  );

  // Condition truth from the flag meanings (R1); X is never consulted.
  function automatic bit ref_cond(int sel, logic [4:0] f);
    bit n, z, v, c, r;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (sel / 2)
      0: r = 1;
      1: r = !(c || z);
      2: r = !c;
      3: r = !z;
      4: r = !v;
      5: r = !n;
      6: r = (n == v);
      default: r = (n == v) && !z;
    endcase
    return (sel % 2) ? !r : r;
  endfunction

  function automatic exp_t ref_model(int o, int sel, logic [4:0] f, logic [31:0] cnt);
    exp_t e;
    int lo;
    e.op = o;
    e.c = ref_cond(sel, f);
    e.t = 0;
    e.cnt = cnt;
    if (o == 1) e.t = e.c;
    if (o == 2 && !e.c) begin
      lo = int'(cnt[15:0]) - 1;
      if (lo < 0) lo = 65535;
      e.cnt = {cnt[31:16], 16'(lo)};
      e.t = (lo != 65535);
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string take_tag(int o, bit c);
    if (o == 1) return "R3";
    if (o == 2) return c ? "R4" : "R5";
    return "R7";
  endfunction

  task automatic compare();
    exp_t e;
    chk(out_valid == (q.size() > 0), "R8", "out_valid", out_valid, q.size() > 0);
    if (out_valid && q.size() > 0) begin
      e = q[0];
      chk(cond_true == e.c, "R1", "cond_true", cond_true, e.c);
      chk(set_byte == (e.c ? 8'hFF : 8'h00), "R2", "set_byte", set_byte, e.c ? 8'hFF : 8'h00);
      chk(taken == e.t, take_tag(e.op, e.c), "taken", taken, e.t);
      chk(cnt_out[15:0] == e.cnt[15:0], take_tag(e.op, e.c), "cnt_low", cnt_out[15:0], e.cnt[15:0]);
      chk(cnt_out[31:16] == e.cnt[31:16], "R6", "cnt_high", cnt_out[31:16], e.cnt[31:16]);
    end
  endtask

  // One cycle: check the current outputs, apply new inputs, update model.
  task automatic step(bit v, int o, int sel, logic [4:0] f, logic [31:0] cnt, bit rdy);
    bit in_fire, out_fire;
    @(negedge clk);
    compare();
    in_valid = v; op = 2'(o); cc_sel = 4'(sel); ccr = f; cnt_in = cnt; out_ready = rdy;
    #1;
    chk(in_ready == (q.size() == 0 || rdy), "R8", "in_ready", in_ready, q.size() == 0 || rdy);
    out_fire = out_valid && rdy;
    in_fire  = v && in_ready;
    if (out_fire) void'(q.pop_front());
    if (in_fire) q.push_back(ref_model(o, sel, f, cnt));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: empty after reset, ready to accept.
    chk(out_valid == 0, "R10", "out_valid", out_valid, 0);
    chk(in_ready == 1, "R10", "in_ready", in_ready, 1);

    // R1/R2/R3/R7: every condition against every flag pattern, ops cycled.
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 32; f++)
        step(1, (s + f) % 4, s, 5'(f), $urandom, 1);

    // R4/R5/R6: loop counter corners, always-false and always-true selects.
    for (int k = 0; k < 4; k++) begin
      logic [15:0] lo;
      lo = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0001 : (k == 2) ? 16'h0002 : 16'hFFFF;
      for (int r = 0; r < 4; r++) begin
        step(1, 2, 1, 5'($urandom), {16'($urandom), lo}, 1);
        step(1, 2, 0, 5'($urandom), {16'($urandom), lo}, 1);
      end
    end

    // R8/R9: random traffic with back-pressure.
    for (int i = 0; i < 4000; i++)
      step($urandom % 4 != 0, $urandom % 4, $urandom % 16, 5'($urandom),
           ($urandom % 3 == 0) ? {16'($urandom), 16'($urandom % 3)} : 32'($urandom),
           $urandom % 3 != 0);

    // Drain.
    for (int i = 0; i < 4; i++) step(0, 0, 0, 5'd0, 32'd0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule